// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers hardware interrupt events from three source groups (receive, transmit and miscellaneous) into per-group 32-bit cause registers. Each group has its own mask, which software sets and clears one bit at a time by writing ones. Each cause bit has its own clear policy. When its policy bit is 1, the bit clears as a side effect of reading the cause register. When its policy bit is 0, the bit clears only when software writes a one to it. Software can also force cause bits high to raise an interrupt on purpose.

The unmasked pending bits of each group are OR-reduced into one bit of a three-bit summary register. The summary register clears when it is read, so no acknowledge write is needed. A separate software mask gates the summary bits, and the result drives a single level-high interrupt line. Register access uses a simple port. A write is a single-cycle strobe. Read data is combinational from the address during a read strobe, and any clear caused by a read takes effect on the clock edge that ends the strobe.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, every group mask reads 0xFFFFFFFF, every clear-policy register reads 0, every cause register reads 0, the summary reads 0, the summary software mask reads 0xFFFFFFFF and `irq` is low.
- R2: Writing to a group's mask-set offset sets the mask bits where the write data is 1. Writing to its mask-clear offset clears the mask bits where the write data is 1. Bits written with 0 keep their value. The current mask is read back at offset 5.
- R3: A cause bit whose clear-policy bit is 1 is cleared by a read of its cause register, and that read returns the value before the clear.
- R4: A cause bit whose clear-policy bit is 0 is cleared only by writing a 1 to it at the cause offset. Reading does not clear it. Writing ones to bits whose policy is 1 has no effect on them.
- R5: Writing ones to a group's cause-set offset sets those cause bits to 1.
- R6: A hardware event bit sets its cause bit on the next clock edge. If a clearing read or a clearing write hits the same bit in the same cycle, the event wins and the bit stays 1.
- R7: The cause register shows pending bits even when they are masked, but masked bits do not reach the summary.
- R8: Summary bit 0 (receive), bit 1 (transmit) and bit 2 (miscellaneous) are each set one cycle after their group has an unmasked pending cause bit.
- R9: Reading the summary (address 24) returns its value and clears it. A group that is still pending sets its bit again in the same edge.
- R10: The summary software mask (address 25) is a 32-bit read/write register. Only bits 2..0 gate the summary bits. `irq` is high while any summary bit is set and its mask bit is 0. Writing 0xFFFFFFFF blocks all groups, and writing 0xFFFFFFF8 enables all three.
- R11: Word address map: the group base is 0 (receive), 8 (transmit) or 16 (miscellaneous). The offsets are 0 cause, 1 mask-set, 2 mask-clear, 3 cause-set, 4 clear-policy and 5 mask readback. Reading offsets 1, 2, 3, 6 and 7 returns 0. Summary is at 24 and its software mask at 25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid while a read strobe is high |
| rx_evt | input | DW | Receive group hardware events |
| tx_evt | input | DW | Transmit group hardware events |
| misc_evt | input | DW | Miscellaneous group hardware events |
| irq | output | 1 | Level-high interrupt request |

## Verification
The hardest situation to reach is a collision: a hardware event that lands in the very cycle a clearing read or a one-to-clear write hits the same bit. The bench makes it happen by raising the event pin at the same falling edge as the access strobe, for both clear policies. A second hard case is a summary read while a group is still pending. The bench first builds up pending bits in all three groups, reads the summary twice to show it refills, and only then clears the causes to watch the latched summary drain on the next read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_GRP = 3;
  localparam int GRP_RX   = 0;
  localparam int GRP_TX   = 1;
  localparam int GRP_MISC = 2;

  localparam int OFS_W    = 3;
  localparam int SUM_PAGE = NUM_GRP;

  localparam logic [OFS_W-1:0] OFS_CAUSE = 3'd0;
  localparam logic [OFS_W-1:0] OFS_MSET  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_MCLR  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_CSET  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MODE  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_MASK  = 3'd5;

  localparam logic [OFS_W-1:0] OFS_SUM   = 3'd0;
  localparam logic [OFS_W-1:0] OFS_SMASK = 3'd1;

  typedef struct packed {
    logic cause_wr;
    logic mset_wr;
    logic mclr_wr;
    logic cset_wr;
    logic mode_wr;
    logic cause_rd;
  } grp_strb_t;
endpackage

// File: rtl/irqc_group.sv
module irqc_group
  import irqc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  grp_strb_t     strb,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] cause_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] mode_q,
  output logic          pend
);

  logic [DW-1:0] cause_d, mask_d, mode_d;
  logic [DW-1:0] clr_vec, set_vec;
  logic          cause_en, mask_en, mode_en;

  // next-state: events and forced sets are applied after clears, so they win
  always_comb begin
    clr_vec  = '0;
    set_vec  = evt;
    if (strb.cause_rd) clr_vec = clr_vec | mode_q;
    if (strb.cause_wr) clr_vec = clr_vec | (wdata & ~mode_q);
    if (strb.cset_wr)  set_vec = set_vec | wdata;
    cause_d  = (cause_q & ~clr_vec) | set_vec;
    cause_en = strb.cause_rd | strb.cause_wr | strb.cset_wr | (|evt);

    mask_d = mask_q;
    if (strb.mset_wr) mask_d = mask_d | wdata;
    if (strb.mclr_wr) mask_d = mask_d & ~wdata;
    mask_en = strb.mset_wr | strb.mclr_wr;

    mode_d  = wdata;
    mode_en = strb.mode_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (mask_en)  mask_q  <= mask_d;
      if (mode_en)  mode_q  <= mode_d;
    end
  end

  assign pend = |(cause_q & ~mask_q);

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary #(
  parameter int DW = 32,
  parameter int NG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NG-1:0] grp_pend,
  input  logic          sum_rd,
  input  logic          smask_wr,
  input  logic [DW-1:0] wdata,
  output logic [NG-1:0] sum_q,
  output logic [DW-1:0] smask_q,
  output logic          irq
);

  logic [NG-1:0] sum_d;
  logic          sum_en;
  logic [DW-1:0] smask_d;
  logic          smask_en;

  always_comb begin
    sum_d    = (sum_rd ? '0 : sum_q) | grp_pend;
    sum_en   = sum_rd | (|grp_pend);
    smask_d  = wdata;
    smask_en = smask_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      smask_q <= '1;
    end else begin
      if (sum_en)   sum_q   <= sum_d;
      if (smask_en) smask_q <= smask_d;
    end
  end

  assign irq = |(sum_q & ~smask_q[NG-1:0]);

endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 5
) (
  input  logic                            reg_en,
  input  logic                            reg_wr,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [NUM_GRP-1:0][DW-1:0]      cause_all,
  input  logic [NUM_GRP-1:0][DW-1:0]      mask_all,
  input  logic [NUM_GRP-1:0][DW-1:0]      mode_all,
  input  logic [NUM_GRP-1:0]              sum_q,
  input  logic [DW-1:0]                   smask_q,
  output grp_strb_t [NUM_GRP-1:0]         strb,
  output logic                            sum_rd,
  output logic                            smask_wr,
  output logic [DW-1:0]                   rdata
);

  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic              wr_stb, rd_stb;

  assign page   = reg_addr[ADDR_W-1:OFS_W];
  assign ofs    = reg_addr[OFS_W-1:0];
  assign wr_stb = reg_en & reg_wr;
  assign rd_stb = reg_en & ~reg_wr;

  always_comb begin
    strb     = '0;
    sum_rd   = 1'b0;
    smask_wr = 1'b0;
    rdata    = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (page == PAGE_W'(g)) begin
        strb[g].cause_wr = wr_stb & (ofs == OFS_CAUSE);
        strb[g].mset_wr  = wr_stb & (ofs == OFS_MSET);
        strb[g].mclr_wr  = wr_stb & (ofs == OFS_MCLR);
        strb[g].cset_wr  = wr_stb & (ofs == OFS_CSET);
        strb[g].mode_wr  = wr_stb & (ofs == OFS_MODE);
        strb[g].cause_rd = rd_stb & (ofs == OFS_CAUSE);
        if (rd_stb) begin
          case (ofs)
            OFS_CAUSE: rdata = cause_all[g];
            OFS_MODE:  rdata = mode_all[g];
            OFS_MASK:  rdata = mask_all[g];
            default:   rdata = '0;
          endcase
        end
      end
    end
    if (page == PAGE_W'(SUM_PAGE)) begin
      sum_rd   = rd_stb & (ofs == OFS_SUM);
      smask_wr = wr_stb & (ofs == OFS_SMASK);
      if (rd_stb) begin
        case (ofs)
          OFS_SUM:   rdata = DW'(sum_q);
          OFS_SMASK: rdata = smask_q;
          default:   rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irqc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     rx_evt,
  input  logic [DW-1:0]     tx_evt,
  input  logic [DW-1:0]     misc_evt,
  output logic              irq
);

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [NUM_GRP-1:0][DW-1:0] evt_all, cause_all, mask_all, mode_all;
  grp_strb_t [NUM_GRP-1:0]    strb;
  logic [NUM_GRP-1:0]         grp_pend, sum_q;
  logic [DW-1:0]              smask_q;
  logic                       sum_rd, smask_wr;

  assign evt_all[GRP_RX]   = rx_evt;
  assign evt_all[GRP_TX]   = tx_evt;
  assign evt_all[GRP_MISC] = misc_evt;

  irqc_decode #(.DW(DW), .ADDR_W(ADDR_W)) u_dec (
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .cause_all (cause_all),
    .mask_all  (mask_all),
    .mode_all  (mode_all),
    .sum_q     (sum_q),
    .smask_q   (smask_q),
    .strb      (strb),
    .sum_rd    (sum_rd),
    .smask_wr  (smask_wr),
    .rdata     (reg_rdata)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    irqc_group #(.DW(DW)) u_grp (
      .clk     (clk),
      .rst_n   (rst_sn),
      .strb    (strb[g]),
      .wdata   (reg_wdata),
      .evt     (evt_all[g]),
      .cause_q (cause_all[g]),
      .mask_q  (mask_all[g]),
      .mode_q  (mode_all[g]),
      .pend    (grp_pend[g])
    );
  end

  irqc_summary #(.DW(DW), .NG(NUM_GRP)) u_sum (
    .clk      (clk),
    .rst_n    (rst_sn),
    .grp_pend (grp_pend),
    .sum_rd   (sum_rd),
    .smask_wr (smask_wr),
    .wdata    (reg_wdata),
    .sum_q    (sum_q),
    .smask_q  (smask_q),
    .irq      (irq)
  );

endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int NG = 3
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          reg_en,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] rx_evt,
  input logic [DW-1:0] cause_rx,
  input logic [DW-1:0] mask_rx,
  input logic [NG-1:0] grp_pend,
  input logic [NG-1:0] sum_q,
  input logic          irq
);

  logic wr_mset, wr_mclr, wr_cset, rd_sum;
  assign wr_mset = reg_en & reg_wr & (reg_addr == AW'(1));
  assign wr_mclr = reg_en & reg_wr & (reg_addr == AW'(2));
  assign wr_cset = reg_en & reg_wr & (reg_addr == AW'(3));
  assign rd_sum  = reg_en & ~reg_wr & (reg_addr == AW'(24));

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_mset |=> ((mask_rx & $past(reg_wdata)) == $past(reg_wdata)));

  assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_mclr |=> ((mask_rx & $past(reg_wdata)) == '0));

  assert_cause_set_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_cset |=> ((cause_rx & $past(reg_wdata)) == $past(reg_wdata)));

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (rx_evt != '0) |=> ((cause_rx & $past(rx_evt)) == $past(rx_evt)));

  assert_sum_follows_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (grp_pend != '0) |=> ((sum_q & $past(grp_pend)) == $past(grp_pend)));

  assert_sum_drains_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_sum && grp_pend == '0) |=> (sum_q == '0));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> (sum_q != '0));

endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.DW(DW), .AW(ADDR_W), .NG(3)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .reg_en    (reg_en),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rx_evt    (rx_evt),
  .cause_rx  (cause_all[0]),
  .mask_rx   (mask_all[0]),
  .grp_pend  (grp_pend),
  .sum_q     (sum_q),
  .irq       (irq)
);

// File: tb/irq_cause_ctrl_test.sv
`timescale 1ns/1ps
module irq_cause_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] rx_evt = '0, tx_evt = '0, misc_evt = '0;
  logic        irq;
  int          vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  irq_cause_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .misc_evt(misc_evt), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int g = 0; g < 3; g++) begin
      rd_chk("R1 mask", 5'(g*8+5), 32'hFFFF_FFFF);
      rd_chk("R1 mode", 5'(g*8+4), 32'h0);
      rd_chk("R1 cause", 5'(g*8), 32'h0);
    end
    rd_chk("R1 smask", 5'd25, 32'hFFFF_FFFF);
    rd_chk("R1 summary", 5'd24, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    wr(5'd2, 32'h0000_FFFF);
    rd_chk("R2 mask-clear", 5'd5, 32'hFFFF_0000);
    wr(5'd1, 32'h0000_0F00);
    rd_chk("R2 mask-set", 5'd5, 32'hFFFF_0F00);
    wr(5'd2, 32'h0);
    rd_chk("R2 zero write", 5'd5, 32'hFFFF_0F00);
    wr(5'd1, 32'hFFFF_FFFF);
    rd_chk("R2 restore", 5'd5, 32'hFFFF_FFFF);
    rd_chk("R11 mset reads zero", 5'd1, 32'h0);
  endtask

  task automatic t_w1c;
    @(negedge clk); tx_evt = 32'h0000_00F0;
    @(negedge clk); tx_evt = '0;
    rd_chk("R6 event captured", 5'd8, 32'h0000_00F0);
    rd_chk("R4 read keeps", 5'd8, 32'h0000_00F0);
    wr(5'd8, 32'h0000_0030);
    rd_chk("R4 w1c partial", 5'd8, 32'h0000_00C0);
    wr(5'd8, 32'h0000_00C0);
    rd_chk("R4 w1c rest", 5'd8, 32'h0);
  endtask

  task automatic t_cor;
    wr(5'd20, 32'h0000_FF00);
    rd_chk("R3 policy readback", 5'd20, 32'h0000_FF00);
    wr(5'd19, 32'h0000_0F0F);
    wr(5'd16, 32'h0000_0F00);
    rd_chk("R5 cause-set / R4 w1c ignored on COR", 5'd16, 32'h0000_0F0F);
    rd_chk("R3 cleared by read", 5'd16, 32'h0000_000F);
    wr(5'd16, 32'h0000_000F);
    rd_chk("R4 cleanup", 5'd16, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(5'd4, 32'h1);
    wr(5'd3, 32'h1);
    @(negedge clk); reg_en = 1'b1; reg_wr = 1'b0; reg_addr = 5'd0; rx_evt = 32'h1;
    #1 d = reg_rdata;
    @(negedge clk); reg_en = 1'b0; rx_evt = '0;
    check("R3 read value", d, 32'h1);
    rd_chk("R6 event beats read clear", 5'd0, 32'h1);
    rd_chk("R3 clear after race", 5'd0, 32'h0);
    wr(5'd4, 32'h0);
    @(negedge clk); tx_evt = 32'h10;
    @(negedge clk); reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 5'd8; reg_wdata = 32'h10;
    @(negedge clk); reg_en = 1'b0; reg_wr = 1'b0; tx_evt = '0;
    rd_chk("R6 event beats w1c", 5'd8, 32'h10);
    wr(5'd8, 32'h10);
    rd_chk("R4 clear after race", 5'd8, 32'h0);
  endtask

  task automatic t_summary;
    wr(5'd3, 32'h8);
    rd_chk("R7 masked bit visible", 5'd0, 32'h8);
    idle(2);
    rd_chk("R7 masked bit no summary", 5'd24, 32'h0);
    wr(5'd2, 32'h8);
    idle(1);
    check("R10 irq blocked", {31'b0, irq}, 32'h0);
    wr(5'd25, 32'hFFFF_FFF8);
    check("R10 irq enabled", {31'b0, irq}, 32'h1);
    rd_chk("R8 rx summary bit", 5'd24, 32'h1);
    rd_chk("R9 refilled while pending", 5'd24, 32'h1);
    wr(5'd10, 32'h4);
    @(negedge clk); tx_evt = 32'h4;
    @(negedge clk); tx_evt = '0;
    idle(1);
    rd_chk("R8 tx summary bit", 5'd24, 32'h3);
    wr(5'd18, 32'h1);
    wr(5'd19, 32'h1);
    idle(1);
    rd_chk("R8 misc summary bit", 5'd24, 32'h7);
    wr(5'd25, 32'hFFFF_FFFF);
    check("R10 all blocked", {31'b0, irq}, 32'h0);
    rd_chk("R10 smask readback", 5'd25, 32'hFFFF_FFFF);
    wr(5'd25, 32'hFFFF_FFF8);
    check("R10 re-enabled", {31'b0, irq}, 32'h1);
    wr(5'd0, 32'h8);
    wr(5'd8, 32'h4);
    wr(5'd16, 32'h1);
    idle(1);
    check("R9 latched irq", {31'b0, irq}, 32'h1);
    rd_chk("R9 latched value", 5'd24, 32'h7);
    rd_chk("R9 drained", 5'd24, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);
    rd_chk("R11 unused offset", 5'd7, 32'h0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_mask();
    t_w1c();
    t_cor();
    t_race();
    t_summary();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule